// File: doc/BRIEF.md
# Serial ADC Interface Controller

This block is a bus-side master for an external converter on a synchronous serial link. Software writes one 32-bit control word. If the start bit is set, the block runs one frame. It raises a frame sync and toggles a serial clock. It shifts a configuration word out MSB first, lets a fixed number of null clocks pass, then shifts the converter's answer in. At the end of the frame the answer is placed right-justified on a result output.

The frame length is programmable and counts every serial clock in the frame. A mode input chooses between two configuration formats:
- **Byte mode:** a fixed 8-bit configuration byte.
- **Extended mode:** a configuration word of up to 16 bits, whose length is given by a count field.

A separate enable drives a free-running sample clock at twice the serial clock rate.

Top module: `sadc_ctrl`

## Requirements
- R1: While reset is held, busy, fsync, sclk, sdo and smp_clk are 0 and result is 0.
- R2: In byte mode (ext_mode=0), a write with bit 14 set and a non-zero frame length in bits 12:8 runs a frame. The frame has exactly that many sclk rising edges. sdo at the first eight rising edges carries bits 7,6,...,0 of the write data.
- R3: In byte mode one null clock follows the configuration byte. sdi is sampled at every later rising edge. The result holds those samples with the last one in bit 0, truncated to 16 bits.
- R4: In extended mode (ext_mode=1), bits 7:0 give a configuration count, limited to 16. sdo then carries bits 16+count-1 down to bit 16 of the write data, MSB first.
- R5: In extended mode three null clocks follow the configuration bits, and sdi is captured at all later rising edges in the same way as R3.
- R6: A write with bit 14 clear starts no frame. It still loads the sample-clock enable (bit 13) and the frame length.
- R7: With the enable set, smp_clk runs freely with a period of half the sclk period. With the enable clear, smp_clk stays 0.
- R8: Any write while busy is high is ignored. The running frame keeps its length, no second frame follows, and the sample-clock enable is unchanged.
- R9: busy and fsync are high for the whole frame, with every sclk rising edge inside it. result keeps its previous value until the frame completes.
- R10: A start write with frame length 0 runs no frame.
- R11: sdo changes only while sclk is low, and it is 0 at every rising edge after the configuration bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ext_mode | input | 1 | 0 = byte configuration, 1 = extended configuration |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 32 | Control word: 31:16 extension, 14 start, 13 sample enable, 12:8 frame length, 7:0 byte/count |
| busy | output | 1 | Frame in progress |
| result | output | 16 | Captured converter answer, right-justified |
| sclk | output | 1 | Serial shift clock, low when idle |
| fsync | output | 1 | Frame sync, high for the whole frame |
| sdo | output | 1 | Serial data to the converter |
| sdi | input | 1 | Serial data from the converter |
| smp_clk | output | 1 | Free-running sample clock |

## Verification
A frame starts on the clock edge that takes the write, so busy is checked at the falling edge right after the write strobe. Each serial bit takes four prescaler ticks of SMP_HALF cycles each, and result and busy change together on the edge that ends the last bit. The bench therefore waits for busy to fall and samples result half a clock later. A bench converter model captures sdo and drives sdi on the sclk edges, so that bit-level checks follow the serial clock and not a fixed cycle count. Hold checks on result and on ignored writes are taken mid-frame and at least sixty cycles after the frame ends, at falling clock edges.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int CFG_W   = 16;
  localparam int LEN_W   = 5;
  localparam int RES_W   = 16;
  localparam int CNT_W   = $clog2(CFG_W + 1) + 1;
  localparam int BYTE_W  = 8;
  localparam int LEN_LO  = 8;
  localparam int SMP_BIT = 13;
  localparam int GO_BIT  = 14;
  localparam int EXT_LO  = 16;
  localparam int NULL_BYTE = 1;
  localparam int NULL_EXT  = 3;

  typedef enum logic {MODE_BYTE = 1'b0, MODE_EXT = 1'b1} cfg_mode_e;
endpackage

// File: rtl/sadc_tick.sv
module sadc_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  output logic tick,
  output logic smp_clk
);
  localparam int PW = $clog2(HALF + 1);

  logic [PW-1:0] pre_q, pre_d;
  logic          ph_q, ph_d;

  assign tick = (pre_q == PW'(HALF - 1));

  always_comb begin
    pre_d = tick ? '0 : pre_q + 1'b1;
    ph_d  = tick ? ~ph_q : ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      pre_q <= pre_d;
      ph_q  <= ph_d;
    end
  end

  assign smp_clk = smp_en & ph_q;
endmodule

// File: rtl/sadc_regs.sv
module sadc_regs
  import sadc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [31:0]            wr_data,
  input  logic                   busy,
  input  logic                   ext_mode,
  output logic                   go,
  output logic [LEN_W-1:0]       frame_len,
  output logic                   smp_en,
  output logic [CFG_W-1:0]       ld_word,
  output logic [CNT_W-1:0]       ld_len,
  output logic [CNT_W-1:0]       ld_skip
);
  logic              accept;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              smp_q, smp_d;
  logic [BYTE_W-1:0] cnt_raw;
  logic [CNT_W-1:0]  cnt;
  logic [CFG_W-1:0]  ext_word;
  cfg_mode_e         mode;

  assign mode     = cfg_mode_e'(ext_mode);
  assign accept   = wr_en & ~busy;
  assign cnt_raw  = wr_data[BYTE_W-1:0];
  assign ext_word = wr_data[EXT_LO +: CFG_W];
  assign go = accept & wr_data[GO_BIT] & (wr_data[LEN_LO +: LEN_W] != '0);

  always_comb begin
    cnt = (cnt_raw > BYTE_W'(CFG_W)) ? CNT_W'(CFG_W) : CNT_W'(cnt_raw);
    if (mode == MODE_EXT) begin
      ld_len  = cnt;
      ld_word = ext_word << (CNT_W'(CFG_W) - cnt);
      ld_skip = cnt + CNT_W'(NULL_EXT);
    end else begin
      ld_len  = CNT_W'(BYTE_W);
      ld_word = {cnt_raw, {(CFG_W - BYTE_W){1'b0}}};
      ld_skip = CNT_W'(BYTE_W + NULL_BYTE);
    end
  end

  always_comb begin
    len_d = accept ? wr_data[LEN_LO +: LEN_W] : len_q;
    smp_d = accept ? wr_data[SMP_BIT] : smp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      smp_q <= 1'b0;
    end else begin
      len_q <= len_d;
      smp_q <= smp_d;
    end
  end

  assign frame_len = len_q;
  assign smp_en    = smp_q;

  // R8
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en |=> $stable(len_q) && $stable(smp_q));
endmodule

// File: rtl/sadc_shift.sv
module sadc_shift
  import sadc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                go,
  input  logic [CFG_W-1:0]    ld_word,
  input  logic [CNT_W-1:0]    ld_len,
  input  logic [CNT_W-1:0]    ld_skip,
  input  logic [LEN_W-1:0]    frame_len,
  input  logic                sdi,
  output logic                busy,
  output logic                sclk,
  output logic                sdo,
  output logic [RES_W-1:0]    result
);
  logic             busy_q, busy_d;
  logic [1:0]       ph_q, ph_d;
  logic [LEN_W-1:0] idx_q, idx_d;
  logic [CFG_W-1:0] tx_q, tx_d;
  logic [RES_W-1:0] rx_q, rx_d, res_q, res_d;
  logic [CNT_W-1:0] cfg_q, cfg_d, skip_q, skip_d;
  logic [CNT_W-1:0] idx_w;

  assign idx_w = CNT_W'(idx_q);

  always_comb begin
    busy_d = busy_q; ph_d = ph_q; idx_d = idx_q; tx_d = tx_q;
    rx_d = rx_q; res_d = res_q; cfg_d = cfg_q; skip_d = skip_q;
    if (go) begin
      busy_d = 1'b1; ph_d = 2'd0; idx_d = '0; tx_d = ld_word;
      rx_d = '0; cfg_d = ld_len; skip_d = ld_skip;
    end else if (busy_q && tick) begin
      ph_d = ph_q + 2'd1;
      if (ph_q == 2'd1 && idx_w >= skip_q)
        rx_d = {rx_q[RES_W-2:0], sdi};
      if (ph_q == 2'd3) begin
        tx_d  = tx_q << 1;
        idx_d = idx_q + 1'b1;
        if (idx_q == frame_len - 1'b1) begin
          busy_d = 1'b0;
          res_d  = rx_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; ph_q <= '0; idx_q <= '0; tx_q <= '0;
      rx_q <= '0; res_q <= '0; cfg_q <= '0; skip_q <= '0;
    end else begin
      busy_q <= busy_d; ph_q <= ph_d; idx_q <= idx_d; tx_q <= tx_d;
      rx_q <= rx_d; res_q <= res_d; cfg_q <= cfg_d; skip_q <= skip_d;
    end
  end

  assign busy   = busy_q;
  assign sclk   = busy_q & ph_q[1];
  assign sdo    = busy_q & (idx_w < cfg_q) & tx_q[CFG_W-1];
  assign result = res_q;

  // R2
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> idx_q < frame_len);
  // R10
  nonzero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> frame_len != '0);
  // R11
  sdo_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk && $past(sclk) |-> $stable(sdo));
endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int SMP_HALF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic             sclk,
  output logic             fsync,
  output logic             sdo,
  input  logic             sdi,
  output logic             smp_clk
);
  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic             tick, go, smp_en;
  logic [LEN_W-1:0] frame_len;
  logic [CFG_W-1:0] ld_word;
  logic [CNT_W-1:0] ld_len, ld_skip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  sadc_tick #(.HALF(SMP_HALF)) u_tick (
    .clk(clk), .rst_n(core_rst_n), .smp_en(smp_en), .tick(tick), .smp_clk(smp_clk));

  sadc_regs u_regs (
    .clk(clk), .rst_n(core_rst_n), .wr_en(wr_en), .wr_data(wr_data), .busy(busy),
    .ext_mode(ext_mode), .go(go), .frame_len(frame_len), .smp_en(smp_en),
    .ld_word(ld_word), .ld_len(ld_len), .ld_skip(ld_skip));

  sadc_shift u_shift (
    .clk(clk), .rst_n(core_rst_n), .tick(tick), .go(go), .ld_word(ld_word),
    .ld_len(ld_len), .ld_skip(ld_skip), .frame_len(frame_len), .sdi(sdi),
    .busy(busy), .sclk(sclk), .sdo(sdo), .result(result));

  assign fsync = busy;

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    busy && $past(busy) |-> $stable(result));
endmodule

// File: tb/test_sadc_ctrl.sv
`timescale 1ns/1ps
module test_sadc_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0, ext_mode = 1'b0, wr_en = 1'b0, sdi = 1'b0;
  logic [31:0] wr_data = '0;
  logic        busy, sclk, fsync, sdo, smp_clk;
  logic [15:0] result;
  int checks = 0, fails = 0, cyc = 0;
  int edges = 0, fs_bad = 0;
  logic [31:0] sdo_bits = '0, pat = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  sadc_ctrl #(.SMP_HALF(2)) i_sadc_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .wr_en(wr_en), .wr_data(wr_data),
    .busy(busy), .result(result), .sclk(sclk), .fsync(fsync), .sdo(sdo), .sdi(sdi),
    .smp_clk(smp_clk));

  // converter model
  always @(posedge fsync) begin edges = 0; fs_bad = 0; sdo_bits = '0; sdi = pat[0]; end
  always @(posedge sclk) begin
    sdo_bits[edges[4:0]] = sdo;
    if (!fsync) fs_bad++;
    edges++;
  end
  always @(negedge sclk) sdi = pat[edges[4:0]];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int cfg_len(input bit ext, input logic [31:0] d);
    if (!ext) return 8;
    return (d[7:0] > 16) ? 16 : int'(d[7:0]);
  endfunction

  function automatic logic [31:0] exp_sdo(input bit ext, input logic [31:0] d, input int len);
    logic [31:0] v = '0;
    int cl = cfg_len(ext, d);
    for (int k = 0; k < len; k++)
      if (k < cl) v[k] = ext ? d[16 + cl - 1 - k] : d[7 - k];
    return v;
  endfunction

  function automatic logic [15:0] exp_res(input bit ext, input logic [31:0] d,
                                         input int len, input logic [31:0] p);
    logic [15:0] r = '0;
    int skip = cfg_len(ext, d) + (ext ? 3 : 1);
    for (int k = skip; k < len; k++) r = {r[14:0], p[k]};
    return r;
  endfunction

  function automatic logic [31:0] mk(input logic [15:0] ext_w, input logic [7:0] lo,
                                    input int len, input bit smp, input bit go_b);
    return {ext_w, 1'b0, go_b, smp, 5'(len), lo};
  endfunction

  task automatic write(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 600 && busy; i++) @(negedge clk);
  endtask

  task automatic run_frame(input bit ext, input logic [31:0] d, input logic [31:0] p);
    int len = int'(d[12:8]);
    logic [15:0] prev = result;
    ext_mode = ext; pat = p;
    write(d);
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    if (len >= 4) begin
      repeat (20) @(negedge clk);
      chk(result == prev, "R9 result held mid-frame", result, prev);
    end
    wait_idle();
    @(negedge clk);
    chk(edges == len, ext ? "R4 edge count" : "R2 edge count", edges, len);
    chk(fs_bad == 0, "R9 fsync over edges", fs_bad, 0);
    chk(sdo_bits == exp_sdo(ext, d, len), ext ? "R4/R11 sdo bits" : "R2/R11 sdo bits",
        sdo_bits, exp_sdo(ext, d, len));
    chk(result == exp_res(ext, d, len, p), ext ? "R5 result" : "R3 result",
        result, exp_res(ext, d, len, p));
  endtask

  task automatic smp_period(output int per, output int rises);
    int t0 = -1;
    logic last = smp_clk;
    per = 0; rises = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (smp_clk && !last) begin
        if (t0 >= 0 && per == 0) per = cyc - t0;
        t0 = cyc; rises++;
      end
      last = smp_clk;
    end
  endtask

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int per, rises, e0;
    logic [15:0] held;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    // R1
    chk({busy, fsync, sclk, sdo, smp_clk} == 5'b0, "R1 outputs in reset",
        {busy, fsync, sclk, sdo, smp_clk}, 0);
    chk(result == 16'h0, "R1 result in reset", result, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed: R2/R3 25-clock byte frame, R4/R5 23-clock extended frame
    run_frame(1'b0, mk(16'h0, 8'hA7, 25, 1'b0, 1'b1), 32'h5A3C_96E1);
    run_frame(1'b1, mk(16'h02D9, 8'd10, 23, 1'b0, 1'b1), 32'hC3A5_0F1E);
    // R4 count above 16 is limited; count 0 sends no configuration
    run_frame(1'b1, mk(16'hB1E5, 8'd200, 31, 1'b0, 1'b1), 32'hFFFF_0001);
    run_frame(1'b1, mk(16'hFFFF, 8'd0, 12, 1'b0, 1'b1), 32'h0000_0FF0);
    // R3 short frame: no result bits
    run_frame(1'b0, mk(16'h0, 8'hFF, 5, 1'b0, 1'b1), 32'hFFFF_FFFF);

    // R10 zero frame length
    ext_mode = 1'b0;
    write(mk(16'h0, 8'h55, 0, 1'b0, 1'b1));
    repeat (40) @(negedge clk);
    chk(busy == 1'b0 && fsync == 1'b0, "R10 no frame for length 0", busy, 0);

    // R7 disabled sample clock
    smp_period(per, rises);
    chk(rises == 0, "R7 smp_clk idle when disabled", rises, 0);
    // R6 write without start: enables sample clock, no frame
    held = result;
    write(mk(16'h0, 8'h33, 17, 1'b1, 1'b0));
    repeat (60) @(negedge clk);
    chk(busy == 1'b0 && fsync == 1'b0, "R6 no frame without start", busy, 0);
    chk(result == held, "R9 result held after non-start write", result, held);
    smp_period(per, rises);
    chk(per == 4, "R6/R7 smp_clk period 4 cycles (sclk 8)", per, 4);

    // R8 write during a frame is ignored
    ext_mode = 1'b0; pat = 32'h1234_5678;
    write(mk(16'h0, 8'h81, 20, 1'b1, 1'b1));
    repeat (30) @(negedge clk);
    write(mk(16'hFFFF, 8'h0F, 31, 1'b0, 1'b1));
    wait_idle();
    @(negedge clk);
    chk(edges == 20, "R8 frame length kept", edges, 20);
    e0 = edges;
    repeat (80) @(negedge clk);
    chk(busy == 1'b0 && edges == e0, "R8 no second frame", busy, 0);
    smp_period(per, rises);
    chk(per == 4, "R8 sample enable kept", per, 4);

    // constrained random frames
    for (int n = 0; n < 40; n++) begin
      bit ext = 1'($urandom);
      int len = 1 + int'($urandom % 31);
      logic [7:0] lo = ext ? 8'($urandom % 20) : 8'($urandom);
      run_frame(ext, mk(16'($urandom), lo, len, 1'($urandom), 1'b1), $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule